// File: doc/BRIEF.md
# Register File Window Remapper

This block translates the 8-bit register-operand addresses issued by a small controller core into 9-bit physical addresses for an internal RAM. The RAM holds a 256-byte base register file at physical 000h-0FFh and a further 256 bytes directly above it at 100h-1FFh. That upper RAM is treated as eight slices of 32 bytes each. A window select register can place any one slice over the top 32 bytes of the base file, at operand addresses E0h-FFh, where the core keeps its sixteen 16-bit working registers.

Software writes the window select register through a simple write strobe and can read it back. Each cycle the core presents an operand address together with a flag that says whether the access is direct or indirect/indexed. The block returns the physical address in the same cycle, with no register on that path. The parameter `INDIRECT_WINDOWED` decides whether indirect and indexed accesses follow the window or always reach the base file.

Top module: `regwin_remap`

## Requirements
- R1: While reset is asserted, and after it, the read-back value of the window select register is 00h, and operand addresses E0h-FFh map to physical 0E0h-0FFh.
- R2: A select value whose upper five bits are 01001b is a valid 32-byte window encoding, and its bits 2..0 give the window number w. With such a value, a direct access to E0h-FFh produces physical 100h + w*20h + (address bits 4..0). For example, 4Fh maps E0h-FFh to 1E0h-1FFh.
- R3: Operand addresses 00h-DFh produce the same physical address with bit 8 clear, whatever the select value and the access type.
- R4: A select value whose upper five bits are not 01001b (including 00h) causes no remap, so E0h-FFh produce physical 0E0h-0FFh.
- R5: Indirect accesses (flag = 1) to E0h-FFh are remapped exactly as direct ones when INDIRECT_WINDOWED = 1. When it is 0, they always produce 0E0h-0FFh.
- R6: After a write, the read-back output returns the full 8-bit written value from the next cycle onward and holds it until the next write.
- R7: An access in the same cycle as a select write is translated with the old select value. The new value governs accesses from the following cycle on.
- R8: Writes are ignored while reset is asserted and during the two clock cycles in which the reset release is synchronised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_we | input | 1 | Write strobe for the window select register |
| sel_wdata | input | 8 | Value to write into the window select register |
| sel_rdata | output | 8 | Read-back of the window select register |
| acc_addr | input | 8 | Operand address from the core |
| acc_indirect | input | 1 | 1 = indirect or indexed access, 0 = direct |
| phys_addr | output | 9 | Translated physical RAM address |

## Verification
The collision that matters here is a select write landing in the same cycle as an access to the windowed range. The translation must use the value held before the write, and the new window must appear only on the next cycle. The bench provokes this by pairing writes with accesses to E0h-FFh in the same cycle and following each with an access to the same address. A behavioural model that updates its own select copy only at the clock edge judges both cycles. The same pairing is repeated during the two-cycle reset release, where the write must leave no trace.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int SEL_W     = 8;
  localparam int TAG_W     = 5;
  localparam logic [TAG_W-1:0] WIN32_TAG = 5'b01001;

  typedef enum logic {
    ACC_DIRECT   = 1'b0,
    ACC_INDIRECT = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/regwin_rst_sync.sv
module regwin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic stage_d;

  assign stage_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= stage_d;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/regwin_sel_reg.sv
module regwin_sel_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (we) q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int WIN_IDX_W = 3
) (
  input  logic [SEL_W-1:0]     sel,
  output logic                 win_valid,
  output logic [WIN_IDX_W-1:0] win_idx
);
  localparam int HI_W = SEL_W - WIN_IDX_W;

  always_comb begin
    win_valid = (sel[SEL_W-1 -: HI_W] == HI_W'(WIN32_TAG));
    win_idx   = sel[WIN_IDX_W-1:0];
  end
endmodule

// File: rtl/regwin_xlate.sv
module regwin_xlate
  import regwin_pkg::*;
#(
  parameter int ADDR_W            = 8,
  parameter int OFS_W             = 5,
  parameter int WIN_IDX_W         = 3,
  parameter bit INDIRECT_WINDOWED = 1'b1
) (
  input  logic [ADDR_W-1:0]    addr,
  input  acc_kind_e            kind,
  input  logic                 win_valid,
  input  logic [WIN_IDX_W-1:0] win_idx,
  output logic [ADDR_W:0]      phys
);
  localparam int TOP_W = ADDR_W - OFS_W;

  logic in_top;
  logic kind_ok;

  generate
    if (INDIRECT_WINDOWED) begin : g_all_kinds
      assign kind_ok = 1'b1;
    end else begin : g_direct_only
      assign kind_ok = (kind == ACC_DIRECT);
    end
  endgenerate

  always_comb begin
    in_top = &addr[ADDR_W-1:OFS_W];
    if (in_top && win_valid && kind_ok)
      phys = {1'b1, {(ADDR_W-OFS_W-WIN_IDX_W){1'b0}}, win_idx, addr[OFS_W-1:0]};
    else
      phys = {1'b0, addr};
  end

  logic unused_top_w;
  assign unused_top_w = (TOP_W > 0);
endmodule

// File: rtl/regwin_remap.sv
module regwin_remap
  import regwin_pkg::*;
#(
  parameter int ADDR_W            = 8,
  parameter int OFS_W             = 5,
  parameter bit INDIRECT_WINDOWED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [SEL_W-1:0]  sel_wdata,
  output logic [SEL_W-1:0]  sel_rdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_indirect,
  output logic [ADDR_W:0]   phys_addr
);
  localparam int WIN_IDX_W = ADDR_W - OFS_W;

  logic                 rst_sync_n;
  logic                 win_valid;
  logic [WIN_IDX_W-1:0] win_idx;
  logic                 we_gated;
  acc_kind_e            kind;

  assign we_gated = sel_we & rst_sync_n;
  assign kind     = acc_indirect ? ACC_INDIRECT : ACC_DIRECT;

  regwin_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  regwin_sel_reg #(.W(SEL_W)) u_sel_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (we_gated),
    .wdata (sel_wdata),
    .q     (sel_rdata)
  );

  regwin_decode #(.WIN_IDX_W(WIN_IDX_W)) u_decode (
    .sel       (sel_rdata),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  regwin_xlate #(
    .ADDR_W            (ADDR_W),
    .OFS_W             (OFS_W),
    .WIN_IDX_W         (WIN_IDX_W),
    .INDIRECT_WINDOWED (INDIRECT_WINDOWED)
  ) u_xlate (
    .addr      (acc_addr),
    .kind      (kind),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .phys      (phys_addr)
  );
endmodule

// File: rtl/regwin_remap_chk.sv
module regwin_remap_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              sel_we,
  input logic [7:0]        sel_wdata,
  input logic [7:0]        sel_rdata,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [ADDR_W:0]   phys_addr
);
  logic top_hit;
  logic tag_ok;
  assign top_hit = &acc_addr[ADDR_W-1:ADDR_W-3];
  assign tag_ok  = (sel_rdata[7:3] == 5'b01001);

  a_r3_low_passthru: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !top_hit |-> (phys_addr == {1'b0, acc_addr}));

  a_r4_invalid_no_remap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tag_ok |-> (phys_addr == {1'b0, acc_addr}));

  a_r2_window_offset: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phys_addr[ADDR_W]) |-> (phys_addr[4:0] == acc_addr[4:0]) && top_hit && tag_ok);

  a_r6_readback: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sel_we |=> (sel_rdata == $past(sel_wdata)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sel_we |=> $stable(sel_rdata));
endmodule

bind regwin_remap regwin_remap_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .sel_we     (sel_we),
  .sel_wdata  (sel_wdata),
  .sel_rdata  (sel_rdata),
  .acc_addr   (acc_addr),
  .phys_addr  (phys_addr)
);

// File: tb/regwin_remap_bench.sv
`timescale 1ns/1ps
module regwin_remap_bench;
  localparam bit IW = 1'b1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel_we;
  logic [7:0] sel_wdata;
  logic [7:0] sel_rdata;
  logic [7:0] acc_addr;
  logic       acc_indirect;
  logic [8:0] phys_addr;

  int n_chk = 0;
  int n_bad = 0;
  int model_sel = 0;
  int rel_cnt = 0;

  always #2 clk = ~clk;

  regwin_remap #(.INDIRECT_WINDOWED(IW)) u_regwin_remap (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_we       (sel_we),
    .sel_wdata    (sel_wdata),
    .sel_rdata    (sel_rdata),
    .acc_addr     (acc_addr),
    .acc_indirect (acc_indirect),
    .phys_addr    (phys_addr)
  );

  // behavioural model of the select register (R1, R6, R7, R8)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_sel = 0;
      rel_cnt   = 0;
    end else begin
      if (rel_cnt >= 2 && sel_we) model_sel = sel_wdata;
      if (rel_cnt < 2) rel_cnt++;
    end
  end

  function automatic int exp_phys(int a, bit ind, int s);
    if (a < 224) return a;
    if (ind && !IW) return a;
    if ((s >> 3) == 9) return 256 + (s & 7) * 32 + (a & 31);
    return a;
  endfunction

  function automatic string tag_of(int a, bit ind, int s);
    if (a < 224) return "R3";
    if (ind) return "R5";
    if ((s >> 3) != 9) return "R4";
    return "R2";
  endfunction

  task automatic compare(string note);
    int e;
    e = exp_phys(acc_addr, acc_indirect, model_sel);
    n_chk++;
    if (phys_addr !== 9'(e)) begin
      n_bad++;
      $display("FAIL %s %s phys addr=%h ind=%0d: got %h exp %h",
               tag_of(acc_addr, acc_indirect, model_sel), note,
               acc_addr, acc_indirect, phys_addr, e);
    end
    n_chk++;
    if (sel_rdata !== 8'(model_sel)) begin
      n_bad++;
      $display("FAIL R6 %s readback: got %h exp %h", note, sel_rdata, model_sel);
    end
  endtask

  // one cycle: drive after falling edge, compare before next rising edge
  task automatic cyc(bit we, int wd, int a, bit ind, string note);
    @(negedge clk);
    sel_we = we; sel_wdata = 8'(wd); acc_addr = 8'(a); acc_indirect = ind;
    #1 compare(note);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired: got hung exp done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel_we = 0; sel_wdata = 0; acc_addr = 0; acc_indirect = 0;
    // R1 and R8: writes attempted during reset
    repeat (3) cyc(1, 'h4F, 'hE5, 0, "R1 R8 in reset");
    @(negedge clk); rst_n = 1'b1;
    // R8: writes during the two-cycle release are ignored
    cyc(1, 'h4F, 'hE6, 0, "R8 release");
    cyc(1, 'h4A, 'hE7, 0, "R8 release");
    cyc(0, 0, 'hF0, 0, "R1 after release");
    // R7: same-cycle write and access uses old value
    cyc(1, 'h4F, 'hE5, 0, "R7 same cycle");
    cyc(0, 0, 'hE5, 0, "R7 next cycle R2 4Fh");
    cyc(0, 0, 'hFF, 0, "R2 4Fh top");
    // R2/R5: every window, edges of range, both access kinds
    for (int w = 0; w < 8; w++) begin
      cyc(1, 'h48 + w, 'hE0, 1, "R7 R5 switch");
      cyc(0, 0, 'hE0, 0, "R2 low edge");
      cyc(0, 0, 'hFF, 1, "R5 indirect");
      cyc(0, 0, 'hDF, 0, "R3 below");
      cyc(0, 0, 'h00, 1, "R3 zero");
    end
    // R4: invalid encodings
    begin
      int bad_vals[6] = '{'hCF, 'h40, 'h0F, 'h57, 'h00, 'h47};
      foreach (bad_vals[i]) begin
        cyc(1, bad_vals[i], 'hEA, 0, "R4 write");
        cyc(0, 0, 'hEA, 0, "R4 invalid");
        cyc(0, 0, 'hFE, 1, "R4 invalid ind");
      end
    end
    // mixed pattern
    for (int k = 0; k < 400; k++) begin
      int r = $urandom;
      cyc(((r >> 20) & 3) == 0, (r & 1) ? ('h48 | ((r >> 9) & 7)) : ((r >> 9) & 255),
          (r >> 1) & 255, (r >> 17) & 1, "mixed");
    end
    // R1: reset again clears the select
    @(negedge clk); rst_n = 1'b0;
    cyc(0, 0, 'hE3, 0, "R1 re-reset");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule